// File: doc/BRIEF.md
# Frame-of-Interest Motion Gate

This block sits after a per-pixel foreground/background classifier in a camera pipeline. It takes one classification bit per pixel as a valid/ready stream. Each beat also carries markers for the first pixel of a frame and the last pixel of a frame. The block counts the foreground pixels of each frame. When the last pixel is accepted, it decides whether the frame shows enough motion to be worth forwarding, or whether it is static and can be discarded. Downstream logic then keeps or drops its buffered copy of the frame on that decision.

The decision comes out as a single-cycle pulse. The pulse carries a keep/drop bit and the final foreground count. The threshold is an ordinary input, sampled once per frame at the first pixel.

Back-pressure rules: `in_ready` is low only during reset. From the first clock after reset it stays high, so a beat is accepted on every cycle in which `in_valid` is high. The input may leave gaps by lowering `in_valid`, and gaps do not disturb the frame in progress. The decision pulse and the abort flag are plain outputs with no handshake. A consumer must capture them in the cycle they are high.

Top module: `fg_motion_gate`

## Requirements
- R1: `dec_count` equals the number of accepted beats with `in_fg`=1, counted from the start-of-frame beat through the end-of-frame beat inclusive.
- R2: `dec_keep` is 1 when the frame's count is strictly greater than the threshold of that frame.
- R3: `dec_keep` is 0 when the frame's count is less than or equal to the threshold, so a count equal to the threshold drops the frame.
- R4: `dec_valid` is high for exactly the one cycle after an end-of-frame beat is accepted inside a frame. A beat with both `in_sof` and `in_eof` set is a complete one-pixel frame.
- R5: An accepted start-of-frame beat while a frame is open abandons the open frame. No decision is issued for the abandoned frame, and `abort_err` pulses in the next cycle. The count restarts from the new start-of-frame beat.
- R6: `threshold` is sampled on the start-of-frame beat. Later changes within the frame do not affect that frame's decision.
- R7: Beats accepted outside a frame (after an end-of-frame and before the next start-of-frame) are not counted, and they raise neither `dec_valid` nor `abort_err`.
- R8: The count saturates at `MAX_PIXELS`, which defaults to 172800 (360×480). The count width is derived from `MAX_PIXELS` so that the full value fits.
- R9: After reset, `dec_valid` and `abort_err` are 0, and `in_ready` is 1 from the first clock after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel beat valid |
| in_ready | output | 1 | Gate accepts a beat |
| in_fg | input | 1 | 1 = pixel classified as foreground |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_eof | input | 1 | Beat is the last pixel of a frame |
| threshold | input | CNT_W | Foreground count the frame must exceed to be kept |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_keep | output | 1 | 1 = forward frame, 0 = drop frame |
| dec_count | output | CNT_W | Final foreground count of the frame |
| abort_err | output | 1 | One-cycle pulse: open frame abandoned by a new start-of-frame |

## Verification
The bench builds the gate with `MAX_PIXELS` = 48, which gives a 6-bit count. Frames a few dozen pixels long can therefore reach the saturation point, and thresholds can be drawn across the whole count range, including values at and above the maximum. At that size, random frames produce counts landing exactly on the threshold and one either side of it. They also produce one-pixel frames, aborted frames and stray beats outside frames, all within a short run.

// File: rtl/fg_gate_pkg.sv
package fg_gate_pkg;
  // Bits needed to hold every count value from 0 to n inclusive.
  function automatic int count_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fg_gate_counter.sv
module fg_gate_counter #(
  parameter int MAX_PIXELS = 172800,
  parameter int CNT_W      = fg_gate_pkg::count_bits(MAX_PIXELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,      // accepted beat that belongs to a frame
  input  logic             restart,   // the beat opens a new frame
  input  logic             fg,
  output logic [CNT_W-1:0] cnt_next,  // count including this beat
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PIXELS);

  logic [CNT_W-1:0] base;

  always_comb begin
    base = restart ? '0 : cnt_q;
    if (fg && base < CAP) cnt_next = base + 1'b1;
    else                  cnt_next = base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_next;
  end

  assert_sat_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && restart) |=> (cnt_q <= 1));
endmodule

// File: rtl/fg_gate_ctrl.sv
module fg_gate_ctrl #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sof,
  input  logic             eof,
  input  logic [CNT_W-1:0] threshold,
  output logic             live,      // accepted beat belongs to a frame
  output logic             close,     // accepted beat ends a frame
  output logic [CNT_W-1:0] thr_eff,   // threshold in force for this beat
  output logic             abort_err
);
  logic             in_frame;
  logic [CNT_W-1:0] thr_q;

  assign live    = acc && (in_frame || sof);
  assign close   = live && eof;
  assign thr_eff = sof ? threshold : thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      thr_q     <= '0;
      abort_err <= 1'b0;
    end else begin
      abort_err <= acc && sof && in_frame;
      if (acc && sof) thr_q <= threshold;
      if (live) in_frame <= !eof;
    end
  end

  assert_thr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !(acc && sof)) |=> $stable(thr_q));
  assert_abort_needs_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sof && !in_frame) |=> !abort_err);
endmodule

// File: rtl/fg_motion_gate.sv
module fg_motion_gate #(
  parameter int MAX_PIXELS = 172800,
  parameter int CNT_W      = fg_gate_pkg::count_bits(MAX_PIXELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_fg,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [CNT_W-1:0] threshold,
  output logic             dec_valid,
  output logic             dec_keep,
  output logic [CNT_W-1:0] dec_count,
  output logic             abort_err
);
  logic             acc, live, close;
  logic [CNT_W-1:0] thr_eff, cnt_next, cnt_q;

  assign acc = in_valid && in_ready;

  fg_gate_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sof(in_sof), .eof(in_eof),
    .threshold(threshold), .live(live), .close(close), .thr_eff(thr_eff),
    .abort_err(abort_err)
  );

  fg_gate_counter #(.MAX_PIXELS(MAX_PIXELS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(live), .restart(in_sof), .fg(in_fg),
    .cnt_next(cnt_next), .cnt_q(cnt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      dec_valid <= 1'b0;
      dec_keep  <= 1'b0;
      dec_count <= '0;
    end else begin
      in_ready  <= 1'b1;
      dec_valid <= close;
      if (close) begin
        dec_keep  <= cnt_next > thr_eff;
        dec_count <= cnt_next;
      end
    end
  end

  assert_dec_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(acc && in_eof));
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_count <= CNT_W'(MAX_PIXELS));
  assert_ready_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
endmodule

// File: tb/fg_motion_gate_test.sv
module fg_motion_gate_test;
  localparam int PERIOD = 10;
  localparam int MAXP   = 48;
  localparam int W      = fg_gate_pkg::count_bits(MAXP);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_fg = 0, in_sof = 0, in_eof = 0;
  logic [W-1:0] threshold = '0;
  logic in_ready, dec_valid, dec_keep, abort_err;
  logic [W-1:0] dec_count;

  fg_motion_gate #(.MAX_PIXELS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fg(in_fg), .in_sof(in_sof), .in_eof(in_eof), .threshold(threshold),
    .dec_valid(dec_valid), .dec_keep(dec_keep), .dec_count(dec_count),
    .abort_err(abort_err)
  );

  always #(PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  string ctx = "";
  bit done = 0;

  // reference model state
  bit m_in = 0; int m_cnt = 0; int m_thr = 0;
  bit e_dec = 0, e_keep = 0, e_err = 0, e_stray = 0; int e_cnt = 0;

  function automatic int sat_add(int c, bit f);
    return (f && c < MAXP) ? c + 1 : c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, ctx, act, exp);
    end
  endtask

  task automatic compare();
    chk(dec_valid == e_dec, e_stray ? "R7" : "R4", dec_valid, e_dec);
    chk(abort_err == e_err, e_stray ? "R7" : "R5", abort_err, e_err);
    if (e_dec && dec_valid) begin
      chk(dec_keep == e_keep, e_keep ? "R2" : "R3", dec_keep, e_keep);
      chk(dec_count == W'(e_cnt), e_cnt == MAXP ? "R8" : "R1", dec_count, e_cnt);
    end
  endtask

  // one clock: check last cycle's results, then drive and predict
  task automatic beat(bit v, bit f, bit s, bit e, int thr);
    @(negedge clk);
    compare();
    in_valid = v; in_fg = f; in_sof = s; in_eof = e; threshold = W'(thr);
    e_dec = 0; e_err = 0; e_stray = 0;
    if (v) begin
      if (s) begin
        e_err = m_in; m_in = 1; m_cnt = 0; m_thr = thr;
      end
      if (m_in) begin
        m_cnt = sat_add(m_cnt, f);
        if (e) begin
          e_dec = 1; e_cnt = m_cnt; e_keep = (m_cnt > m_thr); m_in = 0;
        end
      end else e_stray = 1;
    end
  endtask

  task automatic frame(int len, int fgs, int thr);
    for (int i = 0; i < len; i++)
      beat(1, i < fgs, i == 0, i == len - 1, thr);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    ctx = "reset";
    chk(dec_valid == 0, "R9", dec_valid, 0);
    chk(abort_err == 0, "R9", abort_err, 0);
    chk(in_ready == 1, "R9", in_ready, 1);

    ctx = "equal threshold drops";  frame(10, 5, 5);  beat(0,0,0,0,0);
    ctx = "one above keeps";        frame(10, 6, 5);  beat(0,0,0,0,0);
    ctx = "single pixel frame R4";  frame(1, 1, 0);   frame(1, 0, 0); beat(0,0,0,0,0);
    ctx = "saturation R8";          frame(60, 60, MAXP-1); beat(0,0,0,0,0);
    ctx = "threshold above max";    frame(60, 60, MAXP); beat(0,0,0,0,0);
    ctx = "stray beats R7";         beat(1,1,0,0,0); beat(1,1,0,1,0); beat(0,0,0,0,0);
    ctx = "abort R5";               frame(8, 8, 0); // sof below aborts nothing: frame closed
    beat(1,1,1,0,2); beat(1,1,0,0,2); beat(1,0,1,0,1); beat(1,1,0,1,1); beat(0,0,0,0,0);
    ctx = "abort by one-pixel frame R5"; beat(1,1,1,0,0); beat(1,1,1,1,0); beat(0,0,0,0,0);
    ctx = "mid-frame threshold change R6";
    beat(1,1,1,0,40); beat(1,1,0,0,0); beat(1,1,0,1,0); beat(0,0,0,0,0);
    ctx = "gaps inside frame";
    beat(1,1,1,0,1); beat(0,1,0,0,1); beat(1,1,0,0,1); beat(0,1,0,1,1); beat(1,0,0,1,1);
    beat(0,0,0,0,0);

    ctx = "random";
    for (int n = 0; n < 400; n++) begin
      int len = 1 + $urandom_range(0, 59);
      int dens = $urandom_range(0, 100);
      int thr = $urandom_range(0, MAXP + 3);
      for (int i = 0; i < len; i++) begin
        bit gap = ($urandom_range(0, 9) == 0);
        int t = ($urandom_range(0, 7) == 0) ? $urandom_range(0, MAXP) : thr;
        bit cut = (i == len - 1) && ($urandom_range(0, 15) == 0);
        if (gap) beat(0, 1, 0, 1, t);
        beat(1, $urandom_range(0, 99) < dens, i == 0, (i == len - 1) && !cut, t);
      end
      if ($urandom_range(0, 5) == 0) beat(1, 1, 0, $urandom_range(0, 1), thr);
      if ($urandom_range(0, 3) == 0) beat(0, 0, 0, 0, 0);
    end
    beat(0,0,0,0,0);
    beat(0,0,0,0,0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", ctx, 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule